// File: doc/BRIEF.md
# Three-Wire Serial Register Master

This block issues single register accesses to up to two slave chips over a three-wire bus: one data line that both ends share, a clock the master alone produces, and two active-high chip selects. A user request carries a target flag, a 7-bit register address, a direction flag and a write byte. The master turns the request into one 16-bit frame and shifts it out on the data line. For reads it stops driving the line halfway through the frame, takes the byte the slave returns, and shows that byte on `rd_data`. It pulses `done` when the frame ends.

The first chip select frames every access. The second chip select is raised only for accesses to the second target, so the first target never sees that traffic. The serial clock is the system clock divided by the even parameter `SCK_DIV`. It rests low whenever the chip selects are low. The bidirectional data line appears as a separate output value, output enable and input, so a pad tristate buffer can be placed at the chip edge.

Top module: `tw_reg_master`

## Requirements
- R1: A frame carries, most significant bit first, the register address in bits 15:9, the direction flag in bit 8 (1 = read, 0 = write) and the data byte in bits 7:0. For a read, bits 7:0 of the master's word are zero.
- R2: `cs_all` rises in the cycle after a request is accepted. The first `sck` rise follows one half period (SCK_DIV/2 cycles) later. `sck` is low whenever `cs_all` is low.
- R3: Every frame, read or write, contains exactly 16 rising edges of `sck`.
- R4: In a write, `sda_oe` stays high for the whole frame. `sda_out` changes only in the cycle where `sck` falls, and holds steady while `sck` is high.
- R5: In a read, the master drives the first 8 bits. `sda_oe` drops together with the 8th falling edge of `sck`. The master then captures `sda_in` at the 9th to 16th falling edges, MSB first.
- R6: `cs_b` follows `cs_all` when the request's `req_target` is 1, and stays low for frames with `req_target` 0.
- R7: Each `sck` period is SCK_DIV system cycles: SCK_DIV/2 cycles high, then SCK_DIV/2 cycles low.
- R8: `busy` is high from the cycle after acceptance until the post-frame idle gap ends. A request presented while `busy` is high is ignored and never produces a frame.
- R9: `done` is a one-cycle pulse in the cycle where `cs_all` has just fallen. In that cycle `rd_data` holds the byte of a read. A write leaves `rd_data` unchanged.
- R10: After a frame ends, the chip selects stay low for at least SCK_DIV cycles before the next frame can begin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_target | input | 1 | 0 = first slave, 1 = second slave (adds `cs_b`) |
| req_addr | input | 7 | Register address |
| req_read | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Access in progress or idle gap running |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 8 | Byte returned by the last read |
| sck | output | 1 | Serial clock |
| cs_all | output | 1 | Chip select for every access |
| cs_b | output | 1 | Chip select for second-slave accesses only |
| sda_out | output | 1 | Value driven on the data line |
| sda_oe | output | 1 | Data line drive enable |
| sda_in | input | 1 | Value sensed on the data line |

## Verification
The bench builds the block with SCK_DIV = 6. This gives three-cycle clock phases, so the tests can see a timer counter that wraps one cycle early or late, and can see a gap that lasts only one phase instead of a full period. The short frames (about 105 cycles) leave room for writes and reads to both targets, for all-ones and all-zeros data and addresses, and for back-to-back requests. Requests also arrive in the middle of a frame and during the idle gap, so the ignore rule is tested in both states.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_HI,
    S_LO,
    S_GAP
  } tw_state_e;

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [ADDR_W-1:0] addr,
    input logic              rd,
    input logic [DATA_W-1:0] wdata
  );
    return {addr, rd, (rd ? {DATA_W{1'b0}} : wdata)};
  endfunction
endpackage

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic long_sel,
  output logic expire
);
  localparam int LIM_S = HALF;
  localparam int LIM_L = 2 * HALF;
  localparam int CW    = $clog2(LIM_L + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;

  assign lim_m1 = long_sel ? CW'(LIM_L - 1) : CW'(LIM_S - 1);
  assign expire = run && (cnt_q == lim_m1);

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tw_frame_shifter.sv
module tw_frame_shifter #(
  parameter int FW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] load_word,
  input  logic          tx_shift,
  input  logic          rx_shift,
  input  logic          rx_bit,
  output logic          tx_bit,
  output logic [DW-1:0] rx_byte
);
  logic [FW-1:0] tx_q;
  logic [DW-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load)          tx_q <= load_word;
      else if (tx_shift) tx_q <= {tx_q[FW-2:0], 1'b0};
      if (rx_shift)      rx_q <= {rx_q[DW-2:0], rx_bit};
    end
  end

  assign tx_bit  = tx_q[FW-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/tw_reg_master.sv
module tw_reg_master
  import tw_pkg::*;
#(
  parameter int SCK_DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_target,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_read,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              sck,
  output logic              cs_all,
  output logic              cs_b,
  output logic              sda_out,
  output logic              sda_oe,
  input  logic              sda_in
);
  localparam int HALF = SCK_DIV / 2;
  localparam int BW   = $clog2(FRAME_W + 1);

  tw_state_e         state_q;
  logic [BW-1:0]     bcnt_q;
  logic              rd_q, cs_q, csb_q, sck_q, oe_q, busy_q, done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              expire, accept, fall, last_bit;
  logic              tx_shift, rx_shift;
  logic [DATA_W-1:0] rx_byte;

  assign accept   = (state_q == S_IDLE) && req_valid;
  assign fall     = (state_q == S_HI) && expire;
  assign last_bit = (bcnt_q == BW'(FRAME_W - 1));
  assign tx_shift = fall && !last_bit;
  assign rx_shift = fall && rd_q && (bcnt_q >= BW'(DATA_W));

  tw_phase_timer #(.HALF(HALF)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (state_q != S_IDLE),
    .long_sel (state_q == S_GAP),
    .expire   (expire)
  );

  tw_frame_shifter #(.FW(FRAME_W), .DW(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_word (build_frame(req_addr, req_read, req_wdata)),
    .tx_shift  (tx_shift),
    .rx_shift  (rx_shift),
    .rx_bit    (sda_in),
    .tx_bit    (sda_out),
    .rx_byte   (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      bcnt_q  <= '0;
      rd_q    <= 1'b0;
      cs_q    <= 1'b0;
      csb_q   <= 1'b0;
      sck_q   <= 1'b0;
      oe_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          rd_q    <= req_read;
          cs_q    <= 1'b1;
          csb_q   <= req_target;
          oe_q    <= 1'b1;
          busy_q  <= 1'b1;
          bcnt_q  <= '0;
          state_q <= S_LEAD;
        end
        S_LEAD: if (expire) begin
          sck_q   <= 1'b1;
          state_q <= S_HI;
        end
        S_HI: if (expire) begin
          sck_q  <= 1'b0;
          bcnt_q <= bcnt_q + 1'b1;
          if (rd_q && bcnt_q == BW'(DATA_W - 1)) oe_q <= 1'b0;
          state_q <= S_LO;
        end
        S_LO: if (expire) begin
          if (bcnt_q == BW'(FRAME_W)) begin
            cs_q    <= 1'b0;
            csb_q   <= 1'b0;
            oe_q    <= 1'b0;
            done_q  <= 1'b1;
            if (rd_q) rdata_q <= rx_byte;
            state_q <= S_GAP;
          end else begin
            sck_q   <= 1'b1;
            state_q <= S_HI;
          end
        end
        S_GAP: if (expire) begin
          busy_q  <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = rdata_q;
  assign sck     = sck_q;
  assign cs_all  = cs_q;
  assign cs_b    = csb_q;
  assign sda_oe  = oe_q;
endmodule

// File: rtl/tw_reg_master_chk.sv
module tw_reg_master_chk #(
  parameter int SCK_DIV = 8
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic sck,
  input logic cs_all,
  input logic cs_b,
  input logic sda_out,
  input logic sda_oe
);
  localparam int HALF = SCK_DIV / 2;
  localparam int HW   = $clog2(SCK_DIV + 2);

  logic       sck_d, cs_d;
  logic [4:0] rise_cnt;
  logic [HW-1:0] hi_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      cs_d     <= 1'b0;
      rise_cnt <= '0;
      hi_len   <= '0;
    end else begin
      sck_d <= sck;
      cs_d  <= cs_all;
      if (cs_all && !cs_d)    rise_cnt <= '0;
      else if (sck && !sck_d) rise_cnt <= rise_cnt + 1'b1;
      if (sck) hi_len <= hi_len + 1'b1;
      else     hi_len <= '0;
    end
  end

  a_r2_sck_rests_low: assert property (@(posedge clk) disable iff (rst)
    !cs_all |-> !sck);
  a_r6_csb_inside: assert property (@(posedge clk) disable iff (rst)
    cs_b |-> cs_all);
  a_r4_drive_in_frame: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> cs_all);
  a_r4_sda_hold_high: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(sda_out));
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_at_cs_fall: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(cs_all));
  a_r8_busy_covers_frame: assert property (@(posedge clk) disable iff (rst)
    cs_all |-> busy);
  a_r3_sixteen_rises: assert property (@(posedge clk) disable iff (rst)
    (!cs_all && cs_d) |-> (rise_cnt == 5'd16));
  a_r7_high_phase: assert property (@(posedge clk) disable iff (rst)
    (!sck && sck_d) |-> (hi_len == HW'(HALF)));
endmodule

bind tw_reg_master tw_reg_master_chk #(.SCK_DIV(SCK_DIV)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .sck     (sck),
  .cs_all  (cs_all),
  .cs_b    (cs_b),
  .sda_out (sda_out),
  .sda_oe  (sda_oe)
);

// File: tb/test_tw_reg_master.sv
module test_tw_reg_master;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_DIV    = 6;
  localparam int H          = SCK_DIV / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_target = 1'b0, req_read = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       busy, done, sck, cs_all, cs_b, sda_out, sda_oe;
  logic [7:0] rd_data;
  logic       sda_in = 1'b0;

  int n_cmp = 0, n_bad = 0;

  // expected entry bits: 7 cs, 6 csb, 5 sck, 4 oe, 3 sda, 2 sda checked, 1 busy, 0 done
  logic [7:0]  q[$];
  logic        last_busy = 1'b0;
  logic [7:0]  exp_rd = 8'h00;
  logic [7:0]  slave_byte = 8'h00;
  logic [15:0] cur_word = '0;
  logic        cur_rd = 1'b0;
  logic [15:0] cap = '0;
  int          rises = 0;
  logic        prev_sck = 1'b0, prev_cs = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_reg_master #(.SCK_DIV(SCK_DIV)) i_tw_reg_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_target(req_target),
    .req_addr(req_addr), .req_read(req_read), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .sck(sck), .cs_all(cs_all),
    .cs_b(cs_b), .sda_out(sda_out), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference timeline for one accepted request (R1 R2 R3 R4 R5 R6 R7 R10)
  task automatic push_frame(input logic t, input logic [6:0] a, input logic r, input logic [7:0] wd);
    logic [15:0] w;
    w = {a, r, (r ? 8'h00 : wd)};
    cur_word = w;
    cur_rd   = r;
    for (int k = 0; k < H; k++) q.push_back({1'b1, t, 1'b0, 1'b1, w[15], 1'b1, 1'b1, 1'b0});
    for (int i = 0; i < 16; i++) begin
      logic oeh, oel, sl;
      oeh = !r || (i <= 7);
      oel = !r || (i < 7);
      sl  = (i < 15) ? w[14-i] : w[0];
      for (int k = 0; k < H; k++) q.push_back({1'b1, t, 1'b1, oeh, w[15-i], oeh, 1'b1, 1'b0});
      for (int k = 0; k < H; k++) q.push_back({1'b1, t, 1'b0, oel, sl, oel, 1'b1, 1'b0});
    end
    for (int k = 0; k < 2*H; k++) q.push_back({6'b0, 1'b1, (k == 0)});
  endtask

  task automatic issue(input logic t, input logic [6:0] a, input logic r,
                       input logic [7:0] wd, input logic [7:0] sb);
    @(negedge clk);
    req_valid = 1'b1; req_target = t; req_addr = a; req_read = r; req_wdata = wd;
    if (q.size() == 0 && !last_busy) begin
      push_frame(t, a, r, wd);
      slave_byte = sb;
      if (r) exp_rd = sb;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || last_busy);
  endtask

  // per-cycle comparison and slave model
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      logic [7:0] e;
      e = (q.size() != 0) ? q.pop_front() : 8'h00;
      last_busy = e[1];
      chk("R2/R10 cs_all", {7'b0, cs_all}, {7'b0, e[7]});
      chk("R6 cs_b",       {7'b0, cs_b},   {7'b0, e[6]});
      chk("R7/R3 sck",     {7'b0, sck},    {7'b0, e[5]});
      chk("R4/R5 sda_oe",  {7'b0, sda_oe}, {7'b0, e[4]});
      if (e[2]) chk("R1 sda_out", {7'b0, sda_out}, {7'b0, e[3]});
      chk("R8 busy",       {7'b0, busy},   {7'b0, e[1]});
      chk("R9 done",       {7'b0, done},   {7'b0, e[0]});
      if (done) chk("R9/R5 rd_data", rd_data, exp_rd);
      // slave side: take master bits on rising edges, answer read data
      if (cs_all && !prev_cs) begin rises = 0; cap = '0; end
      if (sck && !prev_sck && cs_all) begin
        rises++;
        if (sda_oe) cap = {cap[14:0], sda_out};
        if (cur_rd && rises >= 9) sda_in = slave_byte[16-rises];
      end
      if (!cs_all && prev_cs) begin
        if (cur_rd) chk("R1/R5 frame head", cap[7:0], cur_word[15:8]);
        else        chk("R1/R4 frame word", cap[7:0], cur_word[7:0]);
        if (!cur_rd) chk("R1/R4 frame head", cap[15:8], cur_word[15:8]);
        sda_in = 1'b0;
      end
      prev_sck = sck;
      prev_cs  = cs_all;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R2 R8 R9)
    chk("R8 reset busy", {7'b0, busy}, 8'h00);
    chk("R2 reset cs_all", {7'b0, cs_all}, 8'h00);
    chk("R9 reset rd_data", rd_data, 8'h00);
    // R1 R4 write to first slave
    issue(1'b0, 7'h55, 1'b0, 8'hC3, 8'h00);
    wait_idle();
    // R5 R6 read from second slave
    issue(1'b1, 7'h2A, 1'b1, 8'h00, 8'hA5);
    wait_idle();
    // R9 a write leaves rd_data alone; extreme patterns R1
    issue(1'b1, 7'h7F, 1'b0, 8'hFF, 8'h00);
    wait_idle();
    issue(1'b0, 7'h00, 1'b0, 8'h00, 8'h00);
    wait_idle();
    // R5 read first slave, zero byte then all-ones
    issue(1'b0, 7'h7F, 1'b1, 8'h00, 8'h00);
    wait_idle();
    issue(1'b0, 7'h01, 1'b1, 8'h00, 8'hFF);
    // R8 request in mid-frame is ignored
    repeat (20) @(negedge clk);
    issue(1'b1, 7'h33, 1'b0, 8'h99, 8'h00);
    // R8 R10 request during the idle gap is ignored
    do @(negedge clk); while (cs_all);
    issue(1'b1, 7'h44, 1'b1, 8'h00, 8'h11);
    wait_idle();
    // R10 back-to-back frames keep the gap
    issue(1'b1, 7'h12, 1'b1, 8'h00, 8'h3C);
    wait_idle();
    issue(1'b0, 7'h34, 1'b0, 8'h5A, 8'h00);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R8 final busy", {7'b0, busy}, 8'h00);
    chk("R9 final rd_data", rd_data, 8'h3C);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule